// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block collects a set of interrupt input wires and converts each one into an interrupt message made of a vector, a 16-bit destination and a 3-bit delivery mode. Each input pin owns a programmable redirection entry. Software reaches the entries through an indirect window. It first writes a register index to a select register. It then reads or writes a 32-bit data window, which exposes either half of the selected entry or the read-only version word.

Each entry sets the pin's polarity, its trigger mode (edge or level) and its mask. When several pins request service in the same cycle, the lowest-numbered pin wins. One message at a time is presented on a valid/ready port, and it stays stable until it is accepted.

An edge event on a masked pin is thrown away. An edge on an unmasked pin waits until the port accepts its message. A level entry becomes busy once its message is accepted and stays busy until software writes an end-of-interrupt register with the matching vector. That write releases every entry programmed with the same vector.

Top module: `ioirq_router`

## Requirements
- R1: After reset every entry reads back with only the mask bit (bit 16 of the low word) set and all other fields zero, the select register reads 0, and no message is presented.
- R2: Window index 0x01 reads the version word: the VERSION parameter in bits 7:0, NUM_PINS-1 in bits 23:16, zero elsewhere.
- R3: A write at byte offset 0x00 loads the 8-bit select register, which reads back at offset 0x00. Offset 0x10 is the data window for the selected index. Entry n has its low word at index 0x10+2n and its high word at 0x11+2n. Indexes that map to nothing read zero and ignore writes.
- R4: Low word layout: vector 7:0, delivery mode 10:8, polarity 13 (1 = active low), busy 14 (read only), trigger 15 (1 = level), mask 16. The high word carries the destination in bits 31:16. All other bits read zero.
- R5: A rising edge of the conditioned input of an unmasked edge entry produces one message carrying that entry's vector, destination and mode.
- R6: Edges that arrive while an entry is masked are discarded. An edge still waiting when the entry is masked is dropped. Unmasking delivers neither kind.
- R7: With the polarity bit set, the input is inverted before edge detection and level sampling.
- R8: An unmasked level entry whose input is active and which is not busy requests a message. After acceptance it is busy, with no further request, until a write to offset 0x40 carries its vector in bits 7:0. That write releases all entries with that vector; other vectors have no effect.
- R9: Among simultaneous requests, the lowest-numbered pin is presented first.
- R10: A presented message holds its fields stable while ready is low. Each accepted edge message retires its event, so one edge gives exactly one message.
- R11: The delivery mode field, for example fixed 0, lowest-priority 1, PMI 2 or INIT 5, is passed unchanged to the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| irq_i | input | NUM_PINS | Interrupt input pins |
| msg_valid_o | output | 1 | Message presented |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_vector_o | output | 8 | Message vector |
| msg_dest_o | output | 16 | Message destination (ID upper byte, extended ID lower byte) |
| msg_mode_o | output | 3 | Message delivery mode |

## Verification
The bench drives single-pin edge pulses, pulses while masked and while blocked behind a held message, active-low edges, two level pins that share a vector, and simultaneous edges on far-apart pins. Edge pulses separate event retirement from repeated delivery. Masked and blocked pulses show whether stale events are dropped rather than stored. The shared-vector level pair tells a matching end-of-interrupt from a non-matching one and checks that one write releases both entries. Simultaneous pulses expose the priority order, and a reference model compares the port and the read data on every cycle.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] OFS_EOI = 8'h40;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam int IDX_ENTRY_BASE = 16;

  localparam int B_MODE = 8;
  localparam int B_POL  = 13;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;
  localparam int B_DEST = 16;

  typedef struct packed {
    logic        mask;
    logic        trig;   // 1 = level
    logic        pol;    // 1 = active low
    logic [2:0]  mode;
    logic [7:0]  vec;
    logic [15:0] dest;
  } entry_t;

  localparam entry_t ENTRY_RST = entry_t'{mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                          mode: 3'd0, vec: 8'd0, dest: 16'd0};
endpackage

// File: rtl/irr_entry_table.sv
module irr_entry_table
  import irr_pkg::*;
#(
  parameter int          NUM_PINS = 24,
  parameter logic [7:0]  VERSION  = 8'h21
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [7:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [NUM_PINS-1:0] busy_i,
  output entry_t              entries_o [NUM_PINS],
  output logic [31:0]         rdata_o,
  output logic                eoi_o,
  output logic [7:0]          eoi_vec_o
);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

  logic [7:0]  sel_q;
  logic        win_wr;
  logic [31:0] win_rd;
  entry_t      ent_q [NUM_PINS];

  assign win_wr = wr_i && (addr_i == OFS_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (wr_i && addr_i == OFS_SEL) sel_q <= wdata_i[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PINS; i++) ent_q[i] <= ENTRY_RST;
    end else if (win_wr) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (sel_q == 8'(IDX_ENTRY_BASE + 2*i)) begin
          ent_q[i].vec  <= wdata_i[7:0];
          ent_q[i].mode <= wdata_i[B_MODE+:3];
          ent_q[i].pol  <= wdata_i[B_POL];
          ent_q[i].trig <= wdata_i[B_TRIG];
          ent_q[i].mask <= wdata_i[B_MASK];
        end else if (sel_q == 8'(IDX_ENTRY_BASE + 2*i + 1)) begin
          ent_q[i].dest <= wdata_i[B_DEST+:16];
        end
      end
    end
  end

  always_comb begin
    win_rd = '0;
    if (sel_q == IDX_VER) win_rd = {8'd0, MAX_PIN, 8'd0, VERSION};
    for (int i = 0; i < NUM_PINS; i++) begin
      if (sel_q == 8'(IDX_ENTRY_BASE + 2*i))
        win_rd = {15'd0, ent_q[i].mask, ent_q[i].trig, busy_i[i], ent_q[i].pol,
                  2'b00, ent_q[i].mode, ent_q[i].vec};
      else if (sel_q == 8'(IDX_ENTRY_BASE + 2*i + 1))
        win_rd = {ent_q[i].dest, 16'd0};
    end
  end

  always_comb begin
    case (addr_i)
      OFS_SEL: rdata_o = {24'd0, sel_q};
      OFS_WIN: rdata_o = win_rd;
      default: rdata_o = '0;
    endcase
  end

  assign entries_o = ent_q;
  assign eoi_o     = wr_i && (addr_i == OFS_EOI);
  assign eoi_vec_o = wdata_i[7:0];

  AST_SEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_SEL) |=> (sel_q == $past(wdata_i[7:0]))); // R3
endmodule

// File: rtl/irr_pin.sv
module irr_pin (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       pol_i,
  input  logic       trig_i,
  input  logic       mask_i,
  input  logic [7:0] vec_i,
  input  logic       eoi_i,
  input  logic [7:0] eoi_vec_i,
  input  logic       acc_i,
  output logic       req_o,
  output logic       busy_o
);
  logic raw, prev_q, rise, pend_q, busy_q, eoi_hit;

  assign raw     = irq_i ^ pol_i;
  assign rise    = raw & ~prev_q;
  assign eoi_hit = eoi_i && (eoi_vec_i == vec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      prev_q <= raw;
      // masked or level: no edge storage, stale events dropped
      if (mask_i || trig_i) pend_q <= 1'b0;
      else                  pend_q <= (pend_q & ~acc_i) | rise;
      if (!trig_i)          busy_q <= 1'b0;
      else if (acc_i)       busy_q <= 1'b1;
      else if (eoi_hit)     busy_q <= 1'b0;
    end
  end

  assign req_o  = ~mask_i & (trig_i ? (raw & ~busy_q) : pend_q);
  assign busy_o = busy_q;

  AST_MASK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> !pend_q); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && trig_i && !eoi_hit) |=> busy_q); // R8
  AST_BUSY_FROM_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(acc_i)); // R8
endmodule

// File: rtl/irr_arb.sv
module irr_arb #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] req_i,
  input  logic [7:0]          vec_i  [NUM_PINS],
  input  logic [15:0]         dest_i [NUM_PINS],
  input  logic [2:0]          mode_i [NUM_PINS],
  input  logic                ready_i,
  output logic                valid_o,
  output logic [7:0]          vec_o,
  output logic [15:0]         dest_o,
  output logic [2:0]          mode_o,
  output logic [NUM_PINS-1:0] acc_o
);
  logic             found, valid_q;
  logic [PIN_W-1:0] pick, sel_q;
  logic [NUM_PINS-1:0] below_mask;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (req_i[i] && !found) begin
        found = 1'b1;
        pick  = PIN_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sel_q   <= '0;
      vec_o   <= '0;
      dest_o  <= '0;
      mode_o  <= '0;
    end else if (!valid_q) begin
      if (found) begin
        valid_q <= 1'b1;
        sel_q   <= pick;
        vec_o   <= vec_i[pick];
        dest_o  <= dest_i[pick];
        mode_o  <= mode_i[pick];
      end
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      acc_o[i]      = valid_q && ready_i && (sel_q == PIN_W'(i));
      below_mask[i] = (PIN_W'(i) < sel_q);
    end
  end

  assign valid_o = valid_q;

  AST_MSG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(vec_o) && $stable(dest_o) && $stable(mode_o))); // R10
  AST_LOWEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> (($past(req_i) & below_mask) == '0)); // R9
  AST_ONE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc_o)); // R10
endmodule

// File: rtl/ioirq_router.sv
module ioirq_router
  import irr_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [7:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic [NUM_PINS-1:0] irq_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [7:0]          msg_vector_o,
  output logic [15:0]         msg_dest_o,
  output logic [2:0]          msg_mode_o
);
  entry_t              entries [NUM_PINS];
  logic [NUM_PINS-1:0] busy, req, acc;
  logic                eoi;
  logic [7:0]          eoi_vec;
  logic [7:0]          vec_a  [NUM_PINS];
  logic [15:0]         dest_a [NUM_PINS];
  logic [2:0]          mode_a [NUM_PINS];

  irr_entry_table #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) i_table (
    .clk_i, .rst_ni,
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy),
    .entries_o (entries),
    .rdata_o   (reg_rdata_o),
    .eoi_o     (eoi),
    .eoi_vec_o (eoi_vec)
  );

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    assign vec_a[gi]  = entries[gi].vec;
    assign dest_a[gi] = entries[gi].dest;
    assign mode_a[gi] = entries[gi].mode;
    irr_pin i_pin (
      .clk_i, .rst_ni,
      .irq_i     (irq_i[gi]),
      .pol_i     (entries[gi].pol),
      .trig_i    (entries[gi].trig),
      .mask_i    (entries[gi].mask),
      .vec_i     (entries[gi].vec),
      .eoi_i     (eoi),
      .eoi_vec_i (eoi_vec),
      .acc_i     (acc[gi]),
      .req_o     (req[gi]),
      .busy_o    (busy[gi])
    );
  end

  irr_arb #(.NUM_PINS(NUM_PINS)) i_arb (
    .clk_i, .rst_ni,
    .req_i   (req),
    .vec_i   (vec_a),
    .dest_i  (dest_a),
    .mode_i  (mode_a),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .vec_o   (msg_vector_o),
    .dest_o  (msg_dest_o),
    .mode_o  (msg_mode_o),
    .acc_o   (acc)
  );
endmodule

// File: tb/test_ioirq_router.sv
module test_ioirq_router;
  timeunit 1ns; timeprecision 1ps;
  localparam int NP = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, ready = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] irq = '0;
  logic mvalid;
  logic [7:0] mvec;
  logic [15:0] mdest;
  logic [2:0] mmode;

  always #2.5 clk = ~clk;

  ioirq_router #(.NUM_PINS(NP), .VERSION(8'h21)) i_ioirq_router (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_i(irq),
    .msg_valid_o(mvalid), .msg_ready_i(ready), .msg_vector_o(mvec),
    .msg_dest_o(mdest), .msg_mode_o(mmode));

  int total = 0, bad = 0;
  bit done = 0;
  string cur_r = "R1";

  // reference model state
  bit m_mask[NP], m_trig[NP], m_pol[NP], m_prev[NP], m_pend[NP], m_busy[NP];
  logic [2:0] m_mode[NP];
  logic [7:0] m_vec[NP];
  logic [15:0] m_dest[NP];
  logic [7:0] m_sel = '0;
  bit m_valid = 0;
  int m_msel = 0;
  logic [7:0] m_mvec;
  logic [15:0] m_mdest;
  logic [2:0] m_mmode;

  task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_window(logic [7:0] s);
    int n;
    if (s == 8'h01) return 32'h0017_0021;
    if (s >= 8'd16 && int'(s) < 16 + 2*NP) begin
      n = (int'(s) - 16) / 2;
      if (s[0] == 1'b0)
        return {15'd0, m_mask[n], m_trig[n], m_busy[n], m_pol[n], 2'b00, m_mode[n], m_vec[n]};
      return {m_dest[n], 16'd0};
    end
    return '0;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h00) return {24'd0, m_sel};
    if (a == 8'h10) return m_window(m_sel);
    return '0;
  endfunction

  task automatic model_step();
    bit raw, edg, hit, acc, eoi;
    bit req[NP];
    int low = -1;
    acc = m_valid && ready;
    eoi = wr && addr == 8'h40;
    for (int i = 0; i < NP; i++) begin
      raw = irq[i] ^ m_pol[i];
      req[i] = !m_mask[i] && (m_trig[i] ? (raw && !m_busy[i]) : m_pend[i]);
      if (req[i] && low < 0) low = i;
    end
    for (int i = 0; i < NP; i++) begin
      raw = irq[i] ^ m_pol[i];
      edg = raw && !m_prev[i];
      hit = acc && m_msel == i;
      if (m_mask[i] || m_trig[i]) m_pend[i] = 0;
      else m_pend[i] = (m_pend[i] && !hit) || edg;
      if (!m_trig[i]) m_busy[i] = 0;
      else if (hit) m_busy[i] = 1;
      else if (eoi && wdata[7:0] == m_vec[i]) m_busy[i] = 0;
      m_prev[i] = raw;
    end
    if (m_valid) begin
      if (ready) m_valid = 0;
    end else if (low >= 0) begin
      m_valid = 1; m_msel = low;
      m_mvec = m_vec[low]; m_mdest = m_dest[low]; m_mmode = m_mode[low];
    end
    if (wr && addr == 8'h00) m_sel = wdata[7:0];
    else if (wr && addr == 8'h10 && m_sel >= 8'd16 && int'(m_sel) < 16 + 2*NP) begin
      int n = (int'(m_sel) - 16) / 2;
      if (m_sel[0] == 1'b0) begin
        m_vec[n] = wdata[7:0]; m_mode[n] = wdata[10:8]; m_pol[n] = wdata[13];
        m_trig[n] = wdata[15]; m_mask[n] = wdata[16];
      end else m_dest[n] = wdata[31:16];
    end
  endtask

  task automatic compare();
    chk(mvalid == m_valid, cur_r, "model valid", 32'(mvalid), 32'(m_valid));
    if (m_valid) begin
      chk(mvec == m_mvec, cur_r, "model vector", 32'(mvec), 32'(m_mvec));
      chk(mdest == m_mdest, cur_r, "model dest", 32'(mdest), 32'(m_mdest));
      chk(mmode == m_mmode, cur_r, "model mode", 32'(mmode), 32'(m_mmode));
    end
    chk(rdata == m_read(addr), cur_r, "model rdata", rdata, m_read(addr));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    tick();
    wr = 0; addr = 8'h00; wdata = '0;
  endtask

  task automatic prog(int n, logic [31:0] lo, logic [31:0] hi);
    wr_reg(8'h00, 8'(16 + 2*n + 1)); wr_reg(8'h10, hi);
    wr_reg(8'h00, 8'(16 + 2*n));     wr_reg(8'h10, lo);
  endtask

  task automatic set_low(int n, logic [31:0] lo);
    wr_reg(8'h00, 8'(16 + 2*n)); wr_reg(8'h10, lo);
  endtask

  task automatic rd_check(logic [7:0] idx, logic [31:0] exp, string r);
    wr_reg(8'h00, idx);
    addr = 8'h10;
    #0.5;
    chk(rdata == exp, r, $sformatf("read idx %h", idx), rdata, exp);
    tick();
    addr = 8'h00;
  endtask

  task automatic wait_msg(int n, string r);
    for (int i = 0; i < n && !mvalid; i++) tick();
    chk(mvalid, r, "message appears", 32'(mvalid), 32'd1);
  endtask

  task automatic accept();
    ready = 1; tick(); ready = 0;
  endtask

  // ticks with ready high, counting accepted messages
  task automatic collect(int n, output int cnt, output logic [15:0] d0, output logic [15:0] d1);
    cnt = 0; d0 = '0; d1 = '0;
    ready = 1;
    for (int i = 0; i < n; i++) begin
      if (mvalid) begin
        if (cnt == 0) d0 = mdest; else if (cnt == 1) d1 = mdest;
        cnt++;
      end
      tick();
    end
    ready = 0;
  endtask

  task automatic pulse(logic [NP-1:0] m);
    irq = irq | m; tick(); irq = irq & ~m; tick();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [15:0] d0, d1;
    logic [7:0] hv;
    for (int i = 0; i < NP; i++) begin
      m_mask[i] = 1; m_trig[i] = 0; m_pol[i] = 0; m_prev[i] = 0; m_pend[i] = 0;
      m_busy[i] = 0; m_mode[i] = '0; m_vec[i] = '0; m_dest[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    // R1 reset state
    cur_r = "R1";
    chk(mvalid == 1'b0, "R1", "valid after reset", 32'(mvalid), 32'd0);
    chk(rdata == 32'd0, "R1", "select after reset", rdata, 32'd0);
    @(negedge clk);
    rd_check(8'h10, 32'h0001_0000, "R1");
    rd_check(8'h3F, 32'h0000_0000, "R1");
    rd_check(8'h3E, 32'h0001_0000, "R1");
    // R2 version
    cur_r = "R2";
    rd_check(8'h01, 32'h0017_0021, "R2");
    // R3 indirect window, unmapped indexes
    cur_r = "R3";
    wr_reg(8'h00, 8'h02); wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_check(8'h02, 32'h0, "R3");
    rd_check(8'h40, 32'h0, "R3");
    wr_reg(8'h00, 8'h5A);
    #0.5;
    chk(rdata == 32'h5A, "R3", "select readback", rdata, 32'h5A);
    // R4 field layout
    cur_r = "R4";
    prog(5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd_check(8'h1A, 32'h0001_A7FF, "R4");
    rd_check(8'h1B, 32'hFFFF_0000, "R4");
    set_low(5, 32'h0001_0000);
    // R5 single edge, R10 hold and retire
    cur_r = "R5";
    prog(3, 32'h0000_0033, 32'h0102_0000);
    pulse(24'h8);
    wait_msg(10, "R5");
    chk(mvec == 8'h33, "R5", "vector", 32'(mvec), 32'h33);
    chk(mdest == 16'h0102, "R5", "dest", 32'(mdest), 32'h0102);
    cur_r = "R10";
    hv = mvec;
    repeat (4) tick();
    chk(mvalid && mvec == hv, "R10", "held while not ready", 32'(mvec), 32'(hv));
    accept();
    collect(10, cnt, d0, d1);
    chk(cnt == 0, "R10", "one message per edge", cnt, 0);
    // R6 masked edges dropped
    cur_r = "R6";
    set_low(3, 32'h0001_0033);
    pulse(24'h8);
    set_low(3, 32'h0000_0033);
    collect(8, cnt, d0, d1);
    chk(cnt == 0, "R6", "masked edge dropped", cnt, 0);
    prog(6, 32'h0000_0066, 32'h0606_0000);
    pulse(24'h48);
    set_low(6, 32'h0001_0066);
    set_low(6, 32'h0000_0066);
    collect(10, cnt, d0, d1);
    chk(cnt == 1, "R6", "waiting edge dropped on mask", cnt, 1);
    chk(d0 == 16'h0102, "R6", "survivor is pin 3", 32'(d0), 32'h0102);
    // R7 polarity
    cur_r = "R7";
    irq[4] = 1; tick();
    prog(4, 32'h0000_2044, 32'h0404_0000);
    collect(5, cnt, d0, d1);
    chk(cnt == 0, "R7", "idle high quiet", cnt, 0);
    irq[4] = 0; tick();
    wait_msg(6, "R7");
    chk(mvec == 8'h44, "R7", "falling edge vector", 32'(mvec), 32'h44);
    accept();
    irq[4] = 1;
    collect(6, cnt, d0, d1);
    chk(cnt == 0, "R7", "rising edge ignored", cnt, 0);
    // R8 level with shared vector
    cur_r = "R8";
    prog(7, 32'h0001_8170, 32'h0700_0000);
    prog(9, 32'h0001_8170, 32'h0900_0000);
    irq[7] = 1; irq[9] = 1; tick();
    set_low(7, 32'h0000_8170);
    set_low(9, 32'h0000_8170);
    collect(10, cnt, d0, d1);
    chk(cnt == 2, "R8", "both level pins sent", cnt, 2);
    chk(d0 == 16'h0700 && d1 == 16'h0900, "R8", "order 7 then 9", {d0, d1}, 32'h0700_0900);
    collect(6, cnt, d0, d1);
    chk(cnt == 0, "R8", "busy blocks repeat", cnt, 0);
    rd_check(8'h1E, 32'h0000_C170, "R8");
    wr_reg(8'h40, 32'h71);
    collect(6, cnt, d0, d1);
    chk(cnt == 0, "R8", "wrong vector EOI", cnt, 0);
    wr_reg(8'h40, 32'h70);
    collect(10, cnt, d0, d1);
    chk(cnt == 2, "R8", "EOI releases both", cnt, 2);
    irq[7] = 0; irq[9] = 0;
    wr_reg(8'h40, 32'h70);
    collect(6, cnt, d0, d1);
    chk(cnt == 0, "R8", "inactive level quiet", cnt, 0);
    // R9 priority
    cur_r = "R9";
    prog(2, 32'h0000_0020, 32'h0200_0000);
    prog(10, 32'h0000_00A0, 32'h0A00_0000);
    pulse(24'h404);
    wait_msg(6, "R9");
    chk(mvec == 8'h20, "R9", "lowest pin first", 32'(mvec), 32'h20);
    collect(10, cnt, d0, d1);
    chk(cnt == 2 && d1 == 16'h0A00, "R9", "pin 10 second", 32'(d1), 32'h0A00);
    // R11 mode passthrough
    cur_r = "R11";
    prog(12, 32'h0000_05C5, 32'h0C00_0000);
    pulse(24'h1000);
    wait_msg(6, "R11");
    chk(mmode == 3'd5, "R11", "INIT mode", 32'(mmode), 32'd5);
    accept();
    set_low(12, 32'h0000_02C2);
    pulse(24'h1000);
    wait_msg(6, "R11");
    chk(mmode == 3'd2 && mvec == 8'hC2, "R11", "PMI mode", {mvec, 21'd0, mmode}, {8'hC2, 21'd0, 3'd2});
    accept();
    repeat (4) tick();
    done = 1;
    summary();
    $finish;
  end
endmodule